// File: doc/BRIEF.md
# Byte-Lane DRAM Module Access Controller

This controller sits between a requester that works in 64-bit words and a memory module made of eight identical byte-wide DRAM devices. The requester hands over a word address with a read/write flag through a valid/ready handshake. The controller splits that address into a row part (upper bits) and a column part (lower bits). It drives both parts, one after the other, on an address bus that all eight devices share.

Each device owns one fixed byte lane of the word. Device k carries bits 8k+7 down to 8k. On a write, the word is cut into those lanes. On a read, the lanes are joined back into a word. A one-cycle completion pulse ends every access and carries the read word. A hold input from the refresh logic prevents a new row strobe from being issued while it is high.

Top module: `dram_module_ctrl`

## Requirements
- R1: After reset, both strobes, the write enable and the done pulse are low, and `req_ready` is high whenever `refresh_hold` is low.
- R2: In the cycle after a request is accepted, the row strobe is high, the column strobe is low, and the shared address bus carries the row, which is the upper ROW_W bits of the word address.
- R3: In the next cycle, the column strobe is high, the row strobe stays high, and the address bus carries the column, which is the lower COL_W bits of the word address.
- R4: Device lane k (k = 0..7) is data-bus bits 8k+7:8k. A read returns lane k of the addressed location in word bits 8k+7:8k. All lanes use the same row and column.
- R5: For a read, `done` is high for exactly one cycle, in the third cycle after acceptance. `rdata` holds the assembled word in that cycle.
- R6: For a write, the address is taken at acceptance. The data word is taken from `req_wdata` one cycle later, when the column strobe is issued with `dram_we` high. After that, the addressed location holds that word.
- R7: While `refresh_hold` is high, `req_ready` is low and no new row strobe begins. A request that is held waiting is served once the hold is released.
- R8: When `done` is high, both strobes are low. The controller is then idle again, so every request opens its row again with a new row strobe.
- R9: `req_ready` is low while an access is in progress, which is whenever a strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address |
| req_wdata | input | 64 | Write word, sampled one cycle after acceptance |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 64 | Read word, valid while done is high |
| refresh_hold | input | 1 | Blocks the start of a new row strobe |
| dram_addr | output | max(ROW_W,COL_W) | Address bus shared by all devices |
| dram_row_stb | output | 1 | Row strobe, active high |
| dram_col_stb | output | 1 | Column strobe, active high |
| dram_we | output | 1 | Write enable during the column strobe |
| dram_wdata | output | 64 | Eight byte lanes to the devices |
| dram_rdata | input | 64 | Eight byte lanes from the devices |

## Verification
The hardest cases to reach from the ports are the timing ones. One is a refresh hold that rises exactly when a request is waiting. Another is a write whose data word changes between acceptance and the column strobe.

For the hold case, directed sequences keep a request waiting while the hold is high, and then release it. For the write case, the bench drives the inverse of the data at acceptance and the true word one cycle later.

The bench models the module as eight separate byte-wide devices. Each device latches the row on the row strobe, so a lane swap or a wrong row/column split shows up as a data miscompare. Seeded random reads and writes cover the rest of the address space, and directed accesses cover the lowest and highest addresses.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ROW  = 2'd1,
        ST_COL  = 2'd2
    } dmc_state_e;
endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
    parameter int ROW_W = 5,
    parameter int COL_W = 3
) (
    input  logic [ROW_W+COL_W-1:0] word_addr,
    output logic [ROW_W-1:0]       row_part,
    output logic [COL_W-1:0]       col_part
);
    // upper bits choose the row, lower bits the column
    assign row_part = word_addr[ROW_W+COL_W-1:COL_W];
    assign col_part = word_addr[COL_W-1:0];
endmodule

// File: rtl/dmc_lanes.sv
module dmc_lanes #(
    parameter int NUM_DEV = 8,
    parameter int DEV_W   = 8,
    localparam int WORD_W = NUM_DEV * DEV_W
) (
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] lanes_out,
    input  logic [WORD_W-1:0] lanes_in,
    output logic [WORD_W-1:0] word_out
);
    // device k owns a fixed slice k of the word
    for (genvar k = 0; k < NUM_DEV; k++) begin : g_lane
        assign lanes_out[k*DEV_W +: DEV_W] = word_in[k*DEV_W +: DEV_W];
        assign word_out[k*DEV_W +: DEV_W]  = lanes_in[k*DEV_W +: DEV_W];
    end
endmodule

// File: rtl/dram_module_ctrl.sv
module dram_module_ctrl #(
    parameter int ROW_W   = 5,
    parameter int COL_W   = 3,
    parameter int NUM_DEV = 8,
    parameter int DEV_W   = 8,
    localparam int ADDR_W = ROW_W + COL_W,
    localparam int BUS_W  = (ROW_W > COL_W) ? ROW_W : COL_W,
    localparam int WORD_W = NUM_DEV * DEV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              done,
    output logic [WORD_W-1:0] rdata,
    input  logic              refresh_hold,
    output logic [BUS_W-1:0]  dram_addr,
    output logic              dram_row_stb,
    output logic              dram_col_stb,
    output logic              dram_we,
    output logic [WORD_W-1:0] dram_wdata,
    input  logic [WORD_W-1:0] dram_rdata
);
    import dmc_pkg::*;

    typedef struct packed {
        dmc_state_e        state;
        logic              row_stb;
        logic              col_stb;
        logic [BUS_W-1:0]  abus;
        logic              we;
        logic [COL_W-1:0]  col_lat;
        logic              write;
        logic [WORD_W-1:0] wword;
        logic              done;
        logic [WORD_W-1:0] rword;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    logic [ROW_W-1:0]  row_part;
    logic [COL_W-1:0]  col_part;
    logic [WORD_W-1:0] lanes_out;
    logic [WORD_W-1:0] word_rd;
    logic              accept;

    dmc_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W)) split_i (
        .word_addr (req_addr),
        .row_part  (row_part),
        .col_part  (col_part)
    );

    dmc_lanes #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) lanes_i (
        .word_in   (ctl_q.wword),
        .lanes_out (lanes_out),
        .lanes_in  (dram_rdata),
        .word_out  (word_rd)
    );

    assign req_ready = (ctl_q.state == ST_IDLE) && !refresh_hold;
    assign accept    = req_valid && req_ready;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (accept) begin
                    ctl_d.state   = ST_ROW;
                    ctl_d.row_stb = 1'b1;
                    ctl_d.abus    = BUS_W'(row_part);
                    ctl_d.col_lat = col_part;
                    ctl_d.write   = req_write;
                end
            end
            ST_ROW: begin
                // data word is taken now, one cycle after the address
                ctl_d.state   = ST_COL;
                ctl_d.col_stb = 1'b1;
                ctl_d.abus    = BUS_W'(ctl_q.col_lat);
                ctl_d.we      = ctl_q.write;
                ctl_d.wword   = req_wdata;
            end
            ST_COL: begin
                ctl_d.state   = ST_IDLE;
                ctl_d.row_stb = 1'b0;
                ctl_d.col_stb = 1'b0;
                ctl_d.we      = 1'b0;
                ctl_d.done    = 1'b1;
                if (!ctl_q.write) ctl_d.rword = word_rd;
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign done         = ctl_q.done;
    assign rdata        = ctl_q.rword;
    assign dram_addr    = ctl_q.abus;
    assign dram_row_stb = ctl_q.row_stb;
    assign dram_col_stb = ctl_q.col_stb;
    assign dram_we      = ctl_q.we;
    assign dram_wdata   = lanes_out;

    // R3: the column strobe only rises while the row strobe is already high
    a_r3_col_after_row: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_col_stb) |-> $past(dram_row_stb));

    // R8: the completion pulse comes with both strobes low
    a_r8_done_strobes_low: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!dram_row_stb && !dram_col_stb));

    // R5: done is a single-cycle pulse
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: no new row strobe starts from a hold cycle
    a_r7_hold_no_row: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_row_stb) |-> !$past(refresh_hold));

    // R9: not ready while a strobe is out
    a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_row_stb || dram_col_stb) |-> !req_ready);

    // R6: write enable only with the column strobe
    a_r6_we_with_col: assert property (@(posedge clk) disable iff (!rst_n)
        dram_we |-> dram_col_stb);
endmodule

// File: tb/dram_module_ctrl_tb_top.sv
module dram_module_ctrl_tb_top;
    localparam int ROW_W  = 5;
    localparam int COL_W  = 3;
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int BUS_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [63:0]       req_wdata = '0;
    logic              done;
    logic [63:0]       rdata;
    logic              refresh_hold = 1'b0;
    logic [BUS_W-1:0]  dram_addr;
    logic              dram_row_stb, dram_col_stb, dram_we;
    logic [63:0]       dram_wdata;
    logic [63:0]       dram_rdata;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dram_module_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .done(done), .rdata(rdata), .refresh_hold(refresh_hold),
        .dram_addr(dram_addr), .dram_row_stb(dram_row_stb),
        .dram_col_stb(dram_col_stb), .dram_we(dram_we),
        .dram_wdata(dram_wdata), .dram_rdata(dram_rdata)
    );

    // eight independent byte-wide device models
    logic [7:0]       dev_mem [8][DEPTH];
    logic [ROW_W-1:0] dev_row [8];
    logic [63:0]      ref_mem [DEPTH];

    function automatic logic [7:0] seed_byte(int k, int idx);
        return 8'((k * 37 + idx * 11) ^ 8'h5a);
    endfunction

    function automatic logic [63:0] seed_word(int idx);
        logic [63:0] w;
        for (int k = 0; k < 8; k++) w[k*8 +: 8] = seed_byte(k, idx);
        return w;
    endfunction

    initial begin
        for (int k = 0; k < 8; k++) begin
            dev_row[k] = '0;
            for (int i = 0; i < DEPTH; i++) dev_mem[k][i] = seed_byte(k, i);
        end
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = seed_word(i);
    end

    always @(posedge clk) begin
        for (int k = 0; k < 8; k++) begin
            if (dram_row_stb && !dram_col_stb) dev_row[k] <= dram_addr[ROW_W-1:0];
            if (dram_col_stb && dram_we)
                dev_mem[k][{dev_row[k], dram_addr[COL_W-1:0]}] <= dram_wdata[k*8 +: 8];
        end
    end

    always_comb begin
        for (int k = 0; k < 8; k++)
            dram_rdata[k*8 +: 8] = dev_mem[k][{dev_row[k], dram_addr[COL_W-1:0]}];
    end

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one access; inputs change at negedge, outputs sampled at negedge
    task automatic access(logic wr, logic [ADDR_W-1:0] a, logic [63:0] d);
        logic [ROW_W-1:0] r;
        logic [COL_W-1:0] c;
        r = a[ADDR_W-1:COL_W];
        c = a[COL_W-1:0];
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = ~d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_wdata = d;              // true data arrives after the address (R6)
        check("R2 row strobe", {62'd0, dram_row_stb, dram_col_stb}, 64'd2);
        check("R2 row addr", 64'(dram_addr), 64'(r));
        check("R9 busy not ready", 64'(req_ready), 64'd0);
        @(negedge clk);
        check("R3 both strobes", {62'd0, dram_row_stb, dram_col_stb}, 64'd3);
        check("R3 col addr", 64'(dram_addr), 64'(c));
        check("R6 write enable", 64'(dram_we), 64'(wr));
        @(negedge clk);
        req_wdata = '0;
        check("R5 done pulse", 64'(done), 64'd1);
        check("R8 strobes low at done", {62'd0, dram_row_stb, dram_col_stb}, 64'd0);
        if (wr) ref_mem[a] = d;
        else    check("R4 assembled lanes", rdata, ref_mem[a]);
        @(negedge clk);
        check("R5 done single", 64'(done), 64'd0);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R1 reset strobes", {61'd0, dram_row_stb, dram_col_stb, dram_we}, 64'd0);
        check("R1 reset done", 64'(done), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", 64'(req_ready), 64'd1);

        // directed: lowest and highest addresses, preloaded lanes (R4)
        access(1'b0, '0, '0);
        access(1'b0, '1, '0);
        access(1'b1, '1, 64'h0123_4567_89ab_cdef);
        access(1'b0, '1, '0);
        access(1'b1, '0, 64'hff00_ee11_dd22_cc33);
        access(1'b0, '0, '0);

        // R7: hold keeps a waiting request out
        refresh_hold = 1'b1;
        req_valid = 1'b1;
        req_write = 1'b0;
        req_addr  = 8'h5c;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R7 hold no ready", 64'(req_ready), 64'd0);
            check("R7 hold no row strobe", 64'(dram_row_stb), 64'd0);
        end
        refresh_hold = 1'b0;
        access(1'b0, 8'h5c, '0);

        // R8: back-to-back accesses to one row still reopen it
        access(1'b1, 8'h40, 64'hdead_beef_0000_0001);
        access(1'b0, 8'h41, '0);
        access(1'b0, 8'h40, '0);

        void'($urandom(32'h1d2c3b4a));
        for (int i = 0; i < 200; i++) begin
            logic [ADDR_W-1:0] a;
            a = ADDR_W'($urandom);
            if ($urandom % 4 == 0) begin
                refresh_hold = 1'b1;
                repeat (1 + $urandom % 3) @(negedge clk);
                refresh_hold = 1'b0;
            end
            access(1'($urandom), a, {$urandom, $urandom});
        end

        // final sweep reads back every word
        for (int i = 0; i < DEPTH; i++) access(1'b0, ADDR_W'(i), '0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule